// File: doc/BRIEF.md
# Configurable Priority-Stack Cache Replacement Engine

This block holds the replacement state of a set-associative cache. For every set it keeps the ways as an ordered stack. Position 0 has the highest priority and position WAYS-1 the lowest. The cache controller presents one access per cycle: a set index, a hit flag and, on a hit, the way that matched. On a miss, the block reports the way to evict in the same cycle. On the next rising edge it commits the reordered stack for that set.

Three sub-policies shape the reordering, and two of them can be selected at run time. The first is where a freshly filled block lands on a miss. The second is how far a hit block climbs. The third is victim choice, which always takes the bottom of the stack. Selecting top insertion with top promotion gives exact least-recently-used replacement. Other settings give insertion-at-bottom, insertion at a programmable depth, or gradual one-step promotion.

After each access, the reordered stack and its set index appear on registered outputs so that the surrounding logic can observe them. The way count and the set count are parameters.

Top module: `prio_repl_engine`

## Requirements
- R1: After a synchronous active-high reset, every set's stack holds way w at position w, for w = 0 to WAYS-1.
- R2: While `acc_valid` is high and `acc_hit` is low, `victim_way` in that same cycle equals the way held at position WAYS-1 of the addressed set.
- R3: A miss with `ins_mode` = 2'b00 places the victim way at position 0. The entries that were at positions 0 to WAYS-2 each move down by one.
- R4: A miss with `ins_mode` = 2'b01 places the victim way at position WAYS-1, which leaves the stack unchanged.
- R5: A miss with `ins_mode` = 2'b10 places the victim way at position `ins_mid_pos`, clamped to WAYS-1. The code 2'b11 behaves like 2'b00.
- R6: A hit with `promo_mode` = 0 moves the hit way to position 0.
- R7: A hit with `promo_mode` = 1 moves the hit way up exactly one position. A hit on the way already at position 0 leaves it there.
- R8: When a way moves from position o to position t (t ≤ o), the entries at positions t to o-1 each shift down by one. All other entries keep their positions. The stack therefore always remains a permutation of the ways.
- R9: Each valid access commits on the next rising edge. In the following cycle, `upd_valid` is high and `upd_stack` holds the new stack. A cycle with `acc_valid` low changes no state and yields `upd_valid` low.
- R10: An access changes only the stack of the set it addresses, and `upd_set` reports that set.
- R11: With `ins_mode` = 2'b00 and `promo_mode` = 0, the victim on every miss is the way whose most recent use lies furthest in the past. Reset counts as use in order WAYS-1 (oldest) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_set | input | $clog2(SETS) | Set index of the access |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_hit_way | input | $clog2(WAYS) | Way that hit (ignored on a miss) |
| ins_mode | input | 2 | Insertion choice: 00 top, 01 bottom, 10 middle, 11 top |
| ins_mid_pos | input | $clog2(WAYS) | Insertion position for the middle mode |
| promo_mode | input | 1 | Promotion choice: 0 to top, 1 up by one |
| victim_way | output | $clog2(WAYS) | Way to evict for the current access's set (combinational) |
| upd_valid | output | 1 | Registered: an update was committed last edge |
| upd_set | output | $clog2(SETS) | Registered: set that was updated |
| upd_stack | output | WAYS*$clog2(WAYS) | Registered new stack, position p at bits [p*W +: W] |

## Verification
The bench sweeps every insertion code, including the alias code and each middle depth, against both promotion rules. After each access it compares the full stack with a queue model. Several corner cases get specific attention. A hit on the way already at the top under one-step promotion is one of them; an off-by-one there would swap the top two entries or corrupt the stack. Insertion at the bottom must leave the stack unchanged, so a shifter that moves entries anyway would show up. Back-to-back accesses to the same set would expose stale state if the read path missed the previous write. A separate age-stamp model confirms true least-recently-used victims. A final sweep over all sets catches an access that disturbs a neighbouring set, or an idle cycle that changes state.

// File: rtl/repl_pkg.sv
package repl_pkg;
  typedef enum logic [1:0] {
    INS_TOP    = 2'b00,
    INS_BOTTOM = 2'b01,
    INS_MIDDLE = 2'b10,
    INS_TOP_B  = 2'b11
  } ins_mode_e;

  typedef enum logic {
    PROMO_TOP = 1'b0,
    PROMO_ONE = 1'b1
  } promo_mode_e;
endpackage

// File: rtl/repl_state_array.sv
module repl_state_array #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW = $clog2(WAYS),
  localparam int SW = $clog2(SETS),
  localparam int STK = WAYS * WW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SW-1:0]  rd_set,
  output logic [STK-1:0] rd_stack,
  input  logic           wr_en,
  input  logic [SW-1:0]  wr_set,
  input  logic [STK-1:0] wr_stack
);
  logic [STK-1:0] init_stack;
  logic [STK-1:0] mem [SETS];

  always_comb begin
    for (int p = 0; p < WAYS; p++) init_stack[p*WW +: WW] = WW'(p);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) mem[s] <= init_stack;
    end else if (wr_en) begin
      mem[wr_set] <= wr_stack;
    end
  end

  assign rd_stack = mem[rd_set];
endmodule

// File: rtl/repl_pos_find.sv
module repl_pos_find #(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic [WAYS*WW-1:0] stack,
  input  logic [WW-1:0]      way,
  output logic [WW-1:0]      pos
);
  always_comb begin
    pos = '0;
    for (int p = 0; p < WAYS; p++) begin
      if (stack[p*WW +: WW] == way) pos = pos | WW'(p);
    end
  end
endmodule

// File: rtl/repl_reorder.sv
module repl_reorder #(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS)
) (
  input  logic [WAYS*WW-1:0] cur,
  input  logic [WW-1:0]      old_pos,
  input  logic [WW-1:0]      tgt_pos,
  output logic [WAYS*WW-1:0] nxt
);
  logic [WW-1:0] mover;
  assign mover = cur[old_pos*WW +: WW];

  for (genvar p = 0; p < WAYS; p++) begin : g_slot
    localparam logic [WW-1:0] PP = WW'(p);
    if (p == 0) begin : g_head
      assign nxt[p*WW +: WW] = (tgt_pos == PP) ? mover : cur[p*WW +: WW];
    end else begin : g_body
      assign nxt[p*WW +: WW] =
        (tgt_pos == PP)                   ? mover :
        (PP > tgt_pos && PP <= old_pos)   ? cur[(p-1)*WW +: WW] :
                                            cur[p*WW +: WW];
    end
  end
endmodule

// File: rtl/prio_repl_engine.sv
module prio_repl_engine #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  localparam int WW = $clog2(WAYS),
  localparam int SW = $clog2(SETS),
  localparam int STK = WAYS * WW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           acc_valid,
  input  logic [SW-1:0]  acc_set,
  input  logic           acc_hit,
  input  logic [WW-1:0]  acc_hit_way,
  input  logic [1:0]     ins_mode,
  input  logic [WW-1:0]  ins_mid_pos,
  input  logic           promo_mode,
  output logic [WW-1:0]  victim_way,
  output logic           upd_valid,
  output logic [SW-1:0]  upd_set,
  output logic [STK-1:0] upd_stack
);
  import repl_pkg::*;

  localparam logic [WW-1:0] LAST = WW'(WAYS - 1);

  logic [STK-1:0] cur_stack, nxt_stack;
  logic [WW-1:0]  hit_pos, old_pos, tgt_pos, mid_clamped;
  ins_mode_e      ins_sel;
  promo_mode_e    promo_sel;

  assign ins_sel   = ins_mode_e'(ins_mode);
  assign promo_sel = promo_mode_e'(promo_mode);

  repl_state_array #(.WAYS(WAYS), .SETS(SETS)) u_state (
    .clk      (clk),
    .rst      (rst),
    .rd_set   (acc_set),
    .rd_stack (cur_stack),
    .wr_en    (acc_valid),
    .wr_set   (acc_set),
    .wr_stack (nxt_stack)
  );

  repl_pos_find #(.WAYS(WAYS)) u_find (
    .stack (cur_stack),
    .way   (acc_hit_way),
    .pos   (hit_pos)
  );

  assign victim_way  = cur_stack[(WAYS-1)*WW +: WW];
  assign mid_clamped = (ins_mid_pos > LAST) ? LAST : ins_mid_pos;

  always_comb begin
    if (acc_hit) begin
      old_pos = hit_pos;
      if (promo_sel == PROMO_ONE) tgt_pos = (hit_pos == '0) ? '0 : hit_pos - 1'b1;
      else                        tgt_pos = '0;
    end else begin
      old_pos = LAST;
      case (ins_sel)
        INS_BOTTOM: tgt_pos = LAST;
        INS_MIDDLE: tgt_pos = mid_clamped;
        default:    tgt_pos = '0;
      endcase
    end
  end

  repl_reorder #(.WAYS(WAYS)) u_reorder (
    .cur     (cur_stack),
    .old_pos (old_pos),
    .tgt_pos (tgt_pos),
    .nxt     (nxt_stack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid <= 1'b0;
      upd_set   <= '0;
      upd_stack <= '0;
    end else begin
      upd_valid <= acc_valid;
      if (acc_valid) begin
        upd_set   <= acc_set;
        upd_stack <= nxt_stack;
      end
    end
  end
endmodule

// File: rtl/repl_engine_checker.sv
module repl_engine_checker #(
  parameter int WAYS = 4,
  localparam int WW = $clog2(WAYS),
  localparam int STK = WAYS * WW
) (
  input logic           clk,
  input logic           rst,
  input logic           acc_valid,
  input logic           acc_hit,
  input logic [WW-1:0]  acc_hit_way,
  input logic [1:0]     ins_mode,
  input logic           promo_mode,
  input logic [WW-1:0]  victim_way,
  input logic           upd_valid,
  input logic [STK-1:0] upd_stack
);
  logic [WAYS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < WAYS; p++) seen[upd_stack[p*WW +: WW]] = 1'b1;
  end

  AST_UPD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> upd_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !upd_valid); // R9
  AST_PERMUTATION: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $countones(seen) == WAYS); // R8
  AST_PROMO_TOP: assert property (@(posedge clk) disable iff (rst)
    acc_valid && acc_hit && !promo_mode |=> upd_stack[WW-1:0] == $past(acc_hit_way)); // R6
  AST_INS_TOP: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_hit && ins_mode == 2'b00 |=> upd_stack[WW-1:0] == $past(victim_way)); // R3
  AST_INS_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    acc_valid && !acc_hit && ins_mode == 2'b01
    |=> upd_stack[(WAYS-1)*WW +: WW] == $past(victim_way)); // R4
endmodule

bind prio_repl_engine repl_engine_checker #(.WAYS(WAYS)) u_repl_chk (
  .clk         (clk),
  .rst         (rst),
  .acc_valid   (acc_valid),
  .acc_hit     (acc_hit),
  .acc_hit_way (acc_hit_way),
  .ins_mode    (ins_mode),
  .promo_mode  (promo_mode),
  .victim_way  (victim_way),
  .upd_valid   (upd_valid),
  .upd_stack   (upd_stack)
);

// File: tb/test_prio_repl_engine.sv
module test_prio_repl_engine;
  localparam int WAYS = 4;
  localparam int SETS = 16;
  localparam int WW = 2;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst;
  logic acc_valid, acc_hit, promo_mode;
  logic [SW-1:0] acc_set;
  logic [WW-1:0] acc_hit_way, ins_mid_pos, victim_way;
  logic [1:0] ins_mode;
  logic upd_valid;
  logic [SW-1:0] upd_set;
  logic [WAYS*WW-1:0] upd_stack;

  always #4 clk = ~clk;

  prio_repl_engine #(.WAYS(WAYS), .SETS(SETS)) i_prio_repl_engine (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .ins_mode(ins_mode),
    .ins_mid_pos(ins_mid_pos), .promo_mode(promo_mode),
    .victim_way(victim_way), .upd_valid(upd_valid), .upd_set(upd_set),
    .upd_stack(upd_stack)
  );

  int checks = 0;
  int errors = 0;
  int seed = 12345;
  longint now = 0;
  bit finished = 0;
  int lru_mode = 0;
  logic [WW-1:0] rq [SETS][WAYS];
  longint last_use [SETS][WAYS];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(int n);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fff) % n;
  endfunction

  function automatic logic [WAYS*WW-1:0] pack(int s);
    logic [WAYS*WW-1:0] v;
    for (int p = 0; p < WAYS; p++) v[p*WW +: WW] = rq[s][p];
    return v;
  endfunction

  task automatic ref_move(int s, int old_p, int tgt_p);
    logic [WW-1:0] m;
    m = rq[s][old_p];
    for (int p = old_p; p > tgt_p; p--) rq[s][p] = rq[s][p-1];
    rq[s][tgt_p] = m;
  endtask

  // Called at a falling edge; returns at the falling edge after the commit.
  task automatic do_access(int s, bit hit, int way, int ins, bit promo, int mid);
    int old_p, tgt_p, w, oldest;
    string req;
    acc_valid = 1'b1; acc_set = SW'(s); acc_hit = hit;
    acc_hit_way = WW'(way); ins_mode = 2'(ins); promo_mode = promo;
    ins_mid_pos = WW'(mid);
    #2;
    w = way;
    if (!hit) begin
      chk(victim_way == rq[s][WAYS-1], "R2", "victim way", victim_way, rq[s][WAYS-1]);
      w = rq[s][WAYS-1];
      old_p = WAYS-1;
      if (lru_mode != 0) begin
        oldest = 0;
        for (int k = 1; k < WAYS; k++)
          if (last_use[s][k] < last_use[s][oldest]) oldest = k;
        chk(victim_way == WW'(oldest), "R11", "LRU victim", victim_way, oldest);
      end
      tgt_p = (ins == 1) ? WAYS-1 : (ins == 2) ? mid : 0;
      req = (ins == 1) ? "R4" : (ins == 2) ? "R5" : "R3";
    end else begin
      old_p = 0;
      for (int p = 0; p < WAYS; p++) if (rq[s][p] == WW'(way)) old_p = p;
      tgt_p = promo ? ((old_p == 0) ? 0 : old_p - 1) : 0;
      req = promo ? "R7" : "R6";
    end
    last_use[s][w] = now;
    now++;
    ref_move(s, old_p, tgt_p);
    @(negedge clk);
    chk(upd_valid == 1'b1, "R9", "update strobe", upd_valid, 1);
    chk(upd_set == SW'(s), "R10", "updated set", upd_set, s);
    chk(upd_stack == pack(s), req, "stack contents", upd_stack, pack(s));
  endtask

  task automatic idle_cycle();
    acc_valid = 1'b0;
    @(negedge clk);
    chk(upd_valid == 1'b0, "R9", "no update when idle", upd_valid, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_set = '0; acc_hit = 1'b0;
    acc_hit_way = '0; ins_mode = '0; ins_mid_pos = '0; promo_mode = 1'b0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        rq[s][w] = WW'(w);
        last_use[s][w] = -w - 1;
      end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(upd_valid == 1'b0, "R9", "idle after reset", upd_valid, 0);

    // R1: bottom-insertion misses expose each set's reset order unchanged.
    for (int s = 0; s < SETS; s++) begin
      acc_valid = 1'b1; acc_set = SW'(s); acc_hit = 1'b0; ins_mode = 2'b01;
      #2;
      chk(victim_way == WW'(WAYS-1), "R1", "reset victim", victim_way, WAYS-1);
      @(negedge clk);
      chk(upd_stack == pack(s), "R1", "reset order", upd_stack, pack(s));
    end
    idle_cycle();

    // R3 R4 R5 R6 R7 R11: sweep every mode combination.
    for (int ins = 0; ins < 4; ins++)
      for (int pr = 0; pr < 2; pr++)
        for (int mid = 0; mid < ((ins == 2) ? WAYS : 1); mid++) begin
          lru_mode = (ins == 0 && pr == 0) ? 1 : 0;
          for (int n = 0; n < 300; n++) begin
            int s;
            s = (n % 5 == 0) ? 3 : rnd(SETS);
            if (n % 11 == 0) begin
              // hit on the top entry, back to back on the same set
              do_access(s, 1'b1, rq[s][0], ins, pr[0], mid);
            end else begin
              do_access(s, rnd(10) < 6, rnd(WAYS), ins, pr[0], mid);
            end
            if (n % 7 == 0) idle_cycle();
          end
        end

    // R8 R10: full reveal of all sets; untouched sets and shifted entries intact.
    for (int s = 0; s < SETS; s++) begin
      acc_valid = 1'b1; acc_set = SW'(s); acc_hit = 1'b0; ins_mode = 2'b01;
      #2;
      chk(victim_way == rq[s][WAYS-1], "R10", "final victim", victim_way, rq[s][WAYS-1]);
      @(negedge clk);
      chk(upd_stack == pack(s), "R8", "final stack", upd_stack, pack(s));
    end
    acc_valid = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule